// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit decides whether a conditional branch is taken. It serves two kinds of branch. The first kind tests a group of condition flags: negative, zero, overflow and carry. It uses a 4-bit condition code, and a per-branch select picks either the 32-bit or the 64-bit flag group. The second kind compares a 64-bit register operand with zero, treating the operand as a signed number.

The decision logic is combinational. Its result is held in a single output register, so `taken_o` shows the decision for the inputs presented at the previous rising clock edge. Target address generation and delay-slot sequencing are handled elsewhere in the pipeline.

Top module: `bce_branch_eval`

## Requirements
- R1: While `rst_ni` is low, `taken_o` is 0.
- R2: `taken_o` presents the decision for the inputs sampled at the previous rising edge of `clk_i`, so the latency is exactly one cycle.
- R3: In the flag family (`fam_i`=0), condition code 0 is never taken and code 8 is always taken, whatever the flags are.
- R4: Flag vectors are packed as {N,Z,V,C}, with bit 3 = N and bit 0 = C. Code 1 is taken on Z and code 9 on not Z. Code 6 is taken on N and code 14 on not N. Code 7 is taken on V and code 15 on not V. Code 5 is taken on C and code 13 on not C.
- R5: The signed conditions are as follows. Code 2 (less or equal) is taken on Z or (N xor V). Code 10 (greater) is its inverse. Code 3 (less) is taken on N xor V. Code 11 (greater or equal) is its inverse.
- R6: The unsigned conditions are as follows. Code 4 (lower or same) is taken on C or Z. Code 12 (higher) is its inverse.
- R7: `wide_sel_i`=1 tests `flags64_i` and `wide_sel_i`=0 tests `flags32_i`. The group that is not selected has no effect on the result.
- R8: In the register family (`fam_i`=1), the unit uses `cond_i[2:0]` and treats `rs_val_i` as a signed 64-bit value with bit 63 as the sign. The tests are: 1 is equal to zero, 5 is not zero, 3 is less than zero, 7 is greater or equal to zero, 2 is less or equal to zero, and 6 is greater than zero.
- R9: In the register family, codes 0 and 4 are never taken. In the register family, `cond_i[3]` and both flag groups have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fam_i | input | 1 | Branch family: 0 tests the flags, 1 tests the register against zero |
| cond_i | input | 4 | Condition code |
| wide_sel_i | input | 1 | Flag group select: 1 selects the 64-bit group, 0 the 32-bit group |
| flags32_i | input | 4 | 32-bit flag group {N,Z,V,C} |
| flags64_i | input | 4 | 64-bit flag group {N,Z,V,C} |
| rs_val_i | input | 64 | Register operand tested against zero |
| taken_o | output | 1 | Branch taken decision, registered |

## Verification
The assertions check the following on every cycle:
- the always and never codes;
- the equal-on-Z condition, using whichever flag group is selected;
- the register equal-to-zero test;
- the reserved register codes.

Only the bench scenarios can show the following:
- the full condition table over every flag combination for both groups;
- that the unselected flag group is ignored;
- the sign boundaries of the register tests, such as a value whose low word is zero but whose upper bits are set, or the largest positive and most negative values.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int unsigned DATA_W  = 64;
    localparam int unsigned COND_W  = 4;
    localparam int unsigned RCODE_W = 3;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bce_flags_t;

    typedef enum logic {
        FAM_FLAGS = 1'b0,
        FAM_REG   = 1'b1
    } bce_fam_e;
endpackage

// File: rtl/bce_flag_eval.sv
module bce_flag_eval
    import bce_pkg::*;
#(
    parameter int unsigned CW = COND_W
) (
    input  logic [CW-1:0] cond_i,
    input  logic          use_wide_i,
    input  bce_flags_t    narrow_i,
    input  bce_flags_t    wide_i,
    output logic          hit_o
);
    localparam int unsigned BASE_W = CW - 1;

    bce_flags_t f;
    logic       base;

    always_comb begin
        f = use_wide_i ? wide_i : narrow_i;
        // The low bits pick a base test; the top bit inverts it.
        unique case (cond_i[BASE_W-1:0])
            3'd0: base = 1'b0;
            3'd1: base = f.z;
            3'd2: base = f.z | (f.n ^ f.v);
            3'd3: base = f.n ^ f.v;
            3'd4: base = f.c | f.z;
            3'd5: base = f.c;
            3'd6: base = f.n;
            default: base = f.v;
        endcase
        hit_o = base ^ cond_i[CW-1];
    end
endmodule

// File: rtl/bce_reg_eval.sv
module bce_reg_eval
    import bce_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned RW = RCODE_W
) (
    input  logic [DW-1:0] val_i,
    input  logic [RW-1:0] code_i,
    output logic          hit_o
);
    logic is_zero;
    logic is_neg;
    logic base;

    always_comb begin
        is_zero = ~|val_i;
        is_neg  = val_i[DW-1];
        unique case (code_i[RW-2:0])
            2'd1:    base = is_zero;
            2'd2:    base = is_neg | is_zero;
            2'd3:    base = is_neg;
            default: base = 1'b0;
        endcase
        // Codes with low bits 00 are reserved and are never taken.
        hit_o = (code_i[RW-2:0] == '0) ? 1'b0 : (base ^ code_i[RW-1]);
    end
endmodule

// File: rtl/bce_branch_eval.sv
module bce_branch_eval
    import bce_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = COND_W,
    parameter int unsigned RW = RCODE_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fam_i,
    input  logic [CW-1:0] cond_i,
    input  logic          wide_sel_i,
    input  logic [3:0]    flags32_i,
    input  logic [3:0]    flags64_i,
    input  logic [DW-1:0] rs_val_i,
    output logic          taken_o
);
    typedef struct packed {
        logic taken;
    } state_t;

    state_t state_d, state_q;
    logic   flag_hit;
    logic   reg_hit;

    bce_flag_eval #(.CW(CW)) u_flag (
        .cond_i     (cond_i),
        .use_wide_i (wide_sel_i),
        .narrow_i   (bce_flags_t'(flags32_i)),
        .wide_i     (bce_flags_t'(flags64_i)),
        .hit_o      (flag_hit)
    );

    bce_reg_eval #(.DW(DW), .RW(RW)) u_reg (
        .val_i  (rs_val_i),
        .code_i (cond_i[RW-1:0]),
        .hit_o  (reg_hit)
    );

    always_comb begin
        state_d = state_q;
        state_d.taken = (bce_fam_e'(fam_i) == FAM_REG) ? reg_hit : flag_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign taken_o = state_q.taken;
endmodule

// File: rtl/bce_branch_eval_chk.sv
module bce_branch_eval_chk #(
    parameter int unsigned DW = 64
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          fam_i,
    input logic [3:0]    cond_i,
    input logic          wide_sel_i,
    input logic [3:0]    flags32_i,
    input logic [3:0]    flags64_i,
    input logic [DW-1:0] rs_val_i,
    input logic          taken_o
);
    AST_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fam_i && cond_i == 4'd8) |=> taken_o); // R3
    AST_NEVER_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fam_i && cond_i == 4'd0) |=> !taken_o); // R3
    AST_EQ_SELECTED_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fam_i && cond_i == 4'd1) |=>
        (taken_o == ($past(wide_sel_i) ? $past(flags64_i[2]) : $past(flags32_i[2])))); // R7
    AST_REG_EQ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fam_i && cond_i[2:0] == 3'd1) |=> (taken_o == ($past(rs_val_i) == '0))); // R8
    AST_REG_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fam_i && cond_i[1:0] == 2'd0) |=> !taken_o); // R9
endmodule

bind bce_branch_eval bce_branch_eval_chk #(.DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fam_i      (fam_i),
    .cond_i     (cond_i),
    .wide_sel_i (wide_sel_i),
    .flags32_i  (flags32_i),
    .flags64_i  (flags64_i),
    .rs_val_i   (rs_val_i),
    .taken_o    (taken_o)
);

// File: tb/bce_branch_eval_bench.sv
module bce_branch_eval_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        fam_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic        wide_sel_i = 1'b0;
    logic [3:0]  flags32_i = '0;
    logic [3:0]  flags64_i = '0;
    logic [63:0] rs_val_i = '0;
    logic        taken_o;

    int n_run  = 0;
    int n_fail = 0;
    logic  exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #2 clk_i = ~clk_i;

    bce_branch_eval u_bce_branch_eval (
        .clk_i(clk_i), .rst_ni(rst_ni), .fam_i(fam_i), .cond_i(cond_i),
        .wide_sel_i(wide_sel_i), .flags32_i(flags32_i), .flags64_i(flags64_i),
        .rs_val_i(rs_val_i), .taken_o(taken_o)
    );

    function automatic logic ref_flag(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'd0:  return 1'b0;
            4'd8:  return 1'b1;
            4'd1:  return z;
            4'd9:  return !z;
            4'd2:  return z | (n ^ v);
            4'd10: return !(z | (n ^ v));
            4'd3:  return n ^ v;
            4'd11: return !(n ^ v);
            4'd4:  return cy | z;
            4'd12: return !(cy | z);
            4'd5:  return cy;
            4'd13: return !cy;
            4'd6:  return n;
            4'd14: return !n;
            4'd7:  return v;
            default: return !v;
        endcase
    endfunction

    function automatic logic ref_reg(input logic [2:0] c, input logic [63:0] x);
        case (c)
            3'd1: return x == 0;
            3'd5: return x != 0;
            3'd3: return $signed(x) < 0;
            3'd7: return $signed(x) >= 0;
            3'd2: return $signed(x) <= 0;
            3'd6: return $signed(x) > 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: taken=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply one input set and push its expected decision.
    task automatic drive(input string tag, input logic fam, input logic [3:0] c,
                         input logic ws, input logic [3:0] f32, input logic [3:0] f64,
                         input logic [63:0] x);
        logic e;
        @(negedge clk_i);
        fam_i = fam; cond_i = c; wide_sel_i = ws;
        flags32_i = f32; flags64_i = f64; rs_val_i = x;
        if (!fam) e = ref_flag(c, ws ? f64 : f32);
        else      e = ref_reg(c[2:0], x);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: just after each edge, compare against the oldest expectation (R2).
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (rst_ni && exp_q.size() > 0) begin
                check(tag_q.pop_front(), taken_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: taken=%b expected=completion", taken_o);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic string cond_tag(input logic [3:0] c);
        case (c)
            4'd0, 4'd8: return "R3";
            4'd2, 4'd3, 4'd10, 4'd11: return "R5";
            4'd4, 4'd12: return "R6";
            default: return "R4";
        endcase
    endfunction

    initial begin
        logic [63:0] vals[8];
        vals = '{64'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                 64'h7FFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 64'h0000_0000_FFFF_FFFF,
                 64'h8000_0000_0000_0001};
        // Reset state: inputs would make the branch taken if it were evaluated.
        cond_i = 4'd8;
        repeat (3) @(posedge clk_i);
        #1 check("R1 reset", taken_o, 1'b0);
        @(negedge clk_i) rst_ni = 1'b1;

        // Full flag table using the 32-bit group; the 64-bit group holds the opposite pattern.
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                drive(cond_tag(4'(c)), 1'b0, 4'(c), 1'b0, 4'(f), ~4'(f), 64'd0);
        // Same table using the 64-bit group (R7).
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                drive("R7", 1'b0, 4'(c), 1'b1, ~4'(f), 4'(f), 64'd0);
        // Register tests at sign boundaries, cond[3] toggled, flags set (R8, R9).
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 8; i++)
                drive((c[1:0] == 2'd0) ? "R9" : "R8", 1'b1, 4'(c), c[0], 4'hF, 4'h0, vals[i]);
        // Back-to-back alternation between families (R2).
        drive("R2", 1'b0, 4'd8, 1'b0, 4'h0, 4'h0, 64'd5);
        drive("R2", 1'b1, 4'd1, 1'b0, 4'h0, 4'h0, 64'd5);
        drive("R2", 1'b0, 4'd1, 1'b1, 4'h0, 4'h4, 64'd0);
        drive("R2", 1'b1, 4'd6, 1'b0, 4'h0, 4'h0, 64'd0);
        @(negedge clk_i);
        @(negedge clk_i);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule